// File: doc/BRIEF.md
# Loss-of-Frame Integrating Timer

This block turns a severely-errored-frame alarm into a loss-of-frame defect. It samples the alarm once per time-base strobe. Each strobe on which the alarm is high adds one unit to an out-of-frame accumulator. The defect is declared once that accumulator reaches a programmed number of strobes. With a 125 µs frame strobe and the default of 24 strobes, this is 3 ms. The thresholds are counted in strobes, so they do not depend on the line rate.

A short alarm-free gap does not undo the accumulation. The accumulator keeps its value and resumes counting when the alarm returns, so bursty errors still lead to the defect. A separate in-frame timer counts consecutive alarm-free strobes. When that timer completes, the accumulator returns to zero and any declared defect is withdrawn. An alarm held high from a loss-of-signal condition therefore produces the defect exactly one threshold period later.

Top module: `lof_integrator`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe on which the alarm is high, `lof_o` is 0.
- R2: Each strobe (`tick_i`=1) with `sef_i`=1 adds one to the accumulated count, which saturates at DECLARE_TICKS. `lof_o` goes to 1 at the clock edge that samples the strobe bringing the count to DECLARE_TICKS (24 by default).
- R3: An alarm-free gap of fewer than CLEAR_TICKS consecutive strobes keeps the accumulated count. For example, 10 alarm strobes, then 5 clean strobes, then 14 alarm strobes set `lof_o` on the last of those alarm strobes.
- R4: When CLEAR_TICKS consecutive strobes (24 by default) all have `sef_i`=0, the accumulated count returns to zero. A later declaration then needs a full DECLARE_TICKS of new alarm strobes.
- R5: `lof_o` returns to 0 at the edge that samples the CLEAR_TICKS-th consecutive alarm-free strobe. Any strobe with `sef_i`=1 restarts this in-frame count from zero.
- R6: Suppose the count of alarm-free strobes stands at CLEAR_TICKS-1 and the next strobe carries `sef_i`=1. That strobe increments the accumulated count and does not reset it.
- R7: In cycles where `tick_i`=0, `sef_i` has no effect and `lof_o` and both timers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| sef_i | input | 1 | Severely-errored-frame alarm level, sampled only on strobes |
| tick_i | input | 1 | One-cycle time-base strobe; one strobe per frame period |
| lof_o | output | 1 | Loss-of-frame defect, registered |

## Verification
Two functions can act on the same strobe: the in-frame timer finishing a gap and the accumulator counting a new alarm strobe. The bench provokes this by running exactly CLEAR_TICKS-1 clean strobes and then one alarm strobe. It judges the result by whether the defect appears after the correct remaining number of alarm strobes. If the gap restart wrongly wins, the defect comes late, and the bench reports it. Random bursts of varied density, compared strobe by strobe against a bench model, also cover other alignments of the gap boundary with an alarm edge.

// File: rtl/lof_pkg.sv
package lof_pkg;

  typedef enum logic {
    LOF_CLEAR    = 1'b0,
    LOF_DECLARED = 1'b1
  } lof_state_e;

endpackage

// File: rtl/lof_oof_timer.sv
module lof_oof_timer #(
  parameter int LIMIT = 24,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sef_i,
  input  logic restart_i,
  output logic declare_o
);

  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (sef_i) begin
        cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
      end else if (restart_i) begin
        cnt_d = '0;
      end
    end
  end

  assign declare_o = tick_i & sef_i & (cnt_d == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
    end
  end

  AST_OOF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R2
  AST_OOF_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !sef_i && !restart_i |=> $stable(cnt_q)); // R3
  AST_OOF_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !sef_i && restart_i |=> cnt_q == '0); // R4
  AST_OOF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/lof_inframe_timer.sv
module lof_inframe_timer #(
  parameter int LIMIT = 24,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sef_i,
  output logic done_o
);

  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (sef_i) begin
        cnt_d = '0;
      end else begin
        cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
      end
    end
  end

  assign done_o = tick_i & ~sef_i & (cnt_d == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
    end
  end

  AST_IF_RESTART_ON_SEF: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && sef_i |=> cnt_q == '0); // R5
  AST_IF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R4
  AST_IF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/lof_integrator.sv
module lof_integrator #(
  parameter int DECLARE_TICKS = 24,
  parameter int CLEAR_TICKS   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sef_i,
  input  logic tick_i,
  output logic lof_o
);
  import lof_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic declare;
  logic gap_done;

  lof_oof_timer #(.LIMIT(DECLARE_TICKS)) u_oof (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .sef_i     (sef_i),
    .restart_i (gap_done),
    .declare_o (declare)
  );

  lof_inframe_timer #(.LIMIT(CLEAR_TICKS)) u_inframe (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_i),
    .sef_i  (sef_i),
    .done_o (gap_done)
  );

  lof_state_e state_q;
  lof_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (declare) begin
      state_d = LOF_DECLARED;
    end else if (gap_done) begin
      state_d = LOF_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= LOF_CLEAR;
    end else if (tick_i) begin
      state_q <= state_d;
    end
  end

  assign lof_o = (state_q == LOF_DECLARED);

  AST_LOF_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(lof_o)); // R7
  AST_LOF_SET_NEEDS_SEF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_o) |-> $past(sef_i) && $past(tick_i)); // R2
  AST_LOF_CLEAR_NEEDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof_o) |-> !$past(sef_i) && $past(tick_i)); // R5
  AST_LOF_RESET_STATE: assert property (@(posedge clk)
    !rst_sync_n |-> !lof_o); // R1

endmodule

// File: tb/test_lof_integrator.sv
module test_lof_integrator;

  localparam int NDECL = 24;
  localparam int NCLR  = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic sef;
  logic tick;
  logic lof;

  always #2ns clk = ~clk;

  lof_integrator #(.DECLARE_TICKS(NDECL), .CLEAR_TICKS(NCLR)) i_lof_integrator (
    .clk    (clk),
    .rst_n  (rst_n),
    .sef_i  (sef),
    .tick_i (tick),
    .lof_o  (lof)
  );

  int n_cmp  = 0;
  int n_bad  = 0;
  bit finished = 1'b0;

  int m_acc   = 0;
  int m_clean = 0;
  bit m_lof   = 1'b0;

  function automatic int sat_inc(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  task automatic model_tick(input bit s);
    if (s) begin
      m_clean = 0;
      m_acc   = sat_inc(m_acc, NDECL);
      if (m_acc == NDECL) m_lof = 1'b1;
    end else begin
      m_clean = sat_inc(m_clean, NCLR);
      if (m_clean == NCLR) begin
        m_acc = 0;
        m_lof = 1'b0;
      end
    end
  endtask

  task automatic check(input bit act, input bit exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: lof_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick(input bit s, input string req);
    @(negedge clk);
    sef  = s;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_tick(s);
    check(lof, m_lof, req);
  endtask

  task automatic run(input bit s, input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(s, req);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick  = 1'b0;
    sef   = 1'b0;
    repeat (3) @(negedge clk);
    check(lof, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_acc = 0; m_clean = 0; m_lof = 1'b0;
    check(lof, 1'b0, "R1");
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1F0F);
    do_reset();

    // R2: 23 alarm strobes stay below, the 24th declares
    run(1'b1, NDECL - 1, "R2");
    check(lof, 1'b0, "R2");
    do_tick(1'b1, "R2");
    check(lof, 1'b1, "R2");

    // R5: 23 clean, one alarm restarts clear count, then 24 clean clears
    run(1'b0, NCLR - 1, "R5");
    check(lof, 1'b1, "R5");
    do_tick(1'b1, "R5");
    run(1'b0, NCLR - 1, "R5");
    check(lof, 1'b1, "R5");
    do_tick(1'b0, "R5");
    check(lof, 1'b0, "R5");

    // R3: bursts separated by short gaps still integrate
    run(1'b1, 10, "R3");
    run(1'b0, 5, "R3");
    run(1'b1, 13, "R3");
    check(lof, 1'b0, "R3");
    do_tick(1'b1, "R3");
    check(lof, 1'b1, "R3");
    run(1'b0, NCLR, "R5");
    check(lof, 1'b0, "R5");

    // R4: a full gap wipes the accumulation
    run(1'b1, 10, "R4");
    run(1'b0, NCLR, "R4");
    run(1'b1, NDECL - 1, "R4");
    check(lof, 1'b0, "R4");
    do_tick(1'b1, "R4");
    check(lof, 1'b1, "R4");
    run(1'b0, NCLR, "R4");

    // R6: alarm on the strobe that would finish the gap
    run(1'b1, 5, "R6");
    run(1'b0, NCLR - 1, "R6");
    do_tick(1'b1, "R6");
    run(1'b1, NDECL - 7, "R6");
    check(lof, 1'b0, "R6");
    do_tick(1'b1, "R6");
    check(lof, 1'b1, "R6");

    // R7: alarm toggling without strobes changes nothing
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sef = ~sef;
    end
    @(negedge clk);
    check(lof, 1'b1, "R7");
    run(1'b0, NCLR - 1, "R7");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sef = (i % 3) == 0;
    end
    @(negedge clk);
    check(lof, 1'b1, "R7");
    do_tick(1'b0, "R7");
    check(lof, 1'b0, "R7");

    // Random bursts of varied density, with idle cycles between strobes
    for (int blk = 0; blk < 60; blk++) begin
      int dens;
      dens = $urandom_range(0, 100);
      for (int k = 0; k < 50; k++) begin
        bit s;
        s = ($urandom_range(0, 99) < dens);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        do_tick(s, "R3");
      end
    end

    // Loss of signal: alarm held high yields defect one threshold later
    run(1'b0, NCLR, "R5");
    run(1'b1, NDECL, "R2");
    check(lof, 1'b1, "R2");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule